// File: doc/BRIEF.md
# Dual-Channel Converter Serial Output Port

This block is the digital side of the serial port on a two-channel, 10-bit sampling converter. A host lowers an active-low select and then toggles a serial clock. The block sends back a 16-bit frame on a serial data line that can be switched off. A digital stand-in for the converter core supplies a 12-bit conversion word: 10 data bits followed by two sub-LSB bits. The block latches that word at the sampling instant.

The level of the serial clock at the moment select falls chooses one of two modes.

- **External-clock mode** (clock low at that moment): the host clock paces everything. The word is latched on the second falling clock edge.
- **Internal-clock mode** (clock high at that moment): the first falling edge starts a busy period, counted in system clocks, that stands in for an on-chip conversion. The data line is held low during this period and then goes high to signal completion. After that the host reads the frame at any rate.

The channel starts at 0 after reset and flips each time select is released. Once the frame has been sent, extra clocks shift out zeros. Raising select during the busy period abandons the conversion.

The pins `cs_n` and `sclk` are sampled by the system clock `clk`. A falling serial clock edge is seen when the sampled value of `sclk` goes from 1 to 0. All outputs are registered, so they respond one system clock after the sampled input change.

Top module: `adc_serial_port`

## Requirements
- R1: On the clock where select is seen falling, `sdo_oe` rises. If `sclk` was high at that clock (internal mode), `sdo` is 0. If `sclk` was low (external mode), `sdo` is 1.
- R2: After reset `chan_sel` is 0. It inverts one clock after each rising edge of `cs_n` and is otherwise constant. The frame carries `chan_sel` as its channel bit.
- R3: Frame bits 1 to 16 are, in order: 1, 1, 1, channel bit, `conv_word[11]` down to `conv_word[0]`. Bits 5 to 14 are the data D9..D0 and bits 15 and 16 are the sub-bits.
- R4: In external mode, bit 1 is driven when select falls, and the n-th `sclk` falling edge drives bit n+1. `conv_word` is latched on the second falling edge, and later changes to it do not alter the frame.
- R5: While `sdo_oe` stays high, `sdo` drops from 1 to 0 only on the clock after a sampled `sclk` falling edge.
- R6: One clock after `cs_n` is sampled high, `sdo_oe` is 0 and `sdo` is 0 (high impedance, shutdown).
- R7: After the last sub-bit, each further `sclk` falling edge drives 0 while select stays low.
- R8: In internal mode, the first `sclk` falling edge latches `conv_word` and starts a busy period of `CONV_CYCLES` clocks. During it `sdo` is 0 and `sclk` edges are ignored. `sdo` goes to 1 on the `CONV_CYCLES`-th clock after the edge was seen.
- R9: In internal mode, after the completion bit, the n-th further `sclk` falling edge drives frame bit n+1, and zeros once past bit 16.
- R10: Raising `cs_n` during the busy period abandons the conversion. The next select cycle, on the other channel, behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low select; high means shutdown |
| sclk | input | 1 | Serial clock from the host |
| conv_word | input | 12 | Conversion result: data in [11:2], sub-bits in [1:0] |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Drive enable for `sdo`; 0 means high impedance |
| chan_sel | output | 1 | Channel that the current or next conversion uses |

## Verification
The checker watches four behaviours on every clock:

- the line is disabled and quiet one clock after select goes high;
- the mode-dependent first value appears when select falls;
- a driven 1-to-0 change on the data line only follows a serial clock falling edge;
- the channel only changes after select is released.

The bench scenarios are needed for everything that depends on content or ordering:

- the exact bit order of frames for several words in both modes;
- the sampling instant in each mode;
- the exact length of the busy period and the fact that clock edges inside it are ignored;
- zero fill after the last sub-bit;
- recovery and channel flip after an abandoned conversion.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int DATA_W      = 10,
  parameter int SUB_W       = 2,
  parameter int CONV_CYCLES = 250
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      sclk,
  input  logic [DATA_W+SUB_W-1:0]   conv_word,
  output logic                      sdo,
  output logic                      sdo_oe,
  output logic                      chan_sel
);
  localparam int WORD_W    = DATA_W + SUB_W;
  localparam int FRAME_LEN = WORD_W + 4;
  localparam int POS_W     = $clog2(FRAME_LEN + 2);
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int CNT_W     = $clog2(CONV_CYCLES + 1);

  logic              active, sclk_q, int_mode, busy, chan_id;
  logic [POS_W-1:0]  pos;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] word_q;

  wire cs_fall   = ~active & ~cs_n;
  wire cs_rise   = active & cs_n;
  wire sclk_fall = active & ~cs_n & sclk_q & ~sclk;

  wire [FRAME_LEN-1:0] frame    = {3'b111, chan_id, word_q};
  wire [POS_W-1:0]     idx_full = POS_W'(FRAME_LEN) - pos;
  wire                 in_frame = (pos != '0) && (pos <= POS_W'(FRAME_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      sclk_q   <= 1'b0;
      int_mode <= 1'b0;
      busy     <= 1'b0;
      chan_id  <= 1'b0;
      pos      <= '0;
      cnt      <= '0;
      word_q   <= '0;
    end else begin
      active <= ~cs_n;
      sclk_q <= sclk;
      if (cs_rise) begin
        chan_id <= ~chan_id;
        busy    <= 1'b0;
        pos     <= '0;
      end else if (cs_fall) begin
        int_mode <= sclk;
        busy     <= 1'b0;
        pos      <= sclk ? '0 : POS_W'(1);
      end else if (active) begin
        if (busy) begin
          if (cnt == '0) begin
            busy <= 1'b0;
            pos  <= POS_W'(1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else if (sclk_fall) begin
          if (int_mode && pos == '0) begin
            busy   <= 1'b1;
            cnt    <= CNT_W'(CONV_CYCLES - 1);
            word_q <= conv_word;
          end else if (pos != '0) begin
            if (!int_mode && pos == POS_W'(2)) word_q <= conv_word;
            if (pos != POS_W'(FRAME_LEN + 1)) pos <= pos + 1'b1;
          end
        end
      end
    end
  end

  assign sdo      = active & in_frame & frame[idx_full[IDX_W-1:0]];
  assign sdo_oe   = active;
  assign chan_sel = chan_id;
endmodule

module adc_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic sdo,
  input logic sdo_oe,
  input logic chan_sel
);
  // R6
  off_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (!sdo_oe && !sdo));

  // R1
  mode_first_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (sdo == !$past(sclk)));

  // R5
  fall_only_on_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && $fell(sdo)) |-> (!$past(sclk) && $past(sclk, 2)));

  // R2
  chan_flip_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_sel) |-> ($past(cs_n) && !$past(cs_n, 2)));
endmodule

bind adc_serial_port adc_serial_port_chk u_chk (.*);

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
  localparam int CONV = 250;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic [11:0] conv_word = '0;
  logic        sdo, sdo_oe, chan_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic exp_ch = 1'b0;

  always #10 clk = ~clk;

  adc_serial_port #(.CONV_CYCLES(CONV)) i_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .conv_word(conv_word),
    .sdo(sdo), .sdo_oe(sdo_oe), .chan_sel(chan_sel));

  // mode bit (1 = internal), then word
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 12'hABC}, {1'b1, 12'h3C5}, {1'b0, 12'h000},
    {1'b1, 12'hFFF}, {1'b0, 12'h5A6}, {1'b1, 12'h801}};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic fbit(input logic ch, input logic [11:0] w, input int k);
    logic [15:0] f;
    f = {3'b111, ch, w};
    return (k >= 1 && k <= 16) ? f[16-k] : 1'b0;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1'b1; wait_n(2);
    sclk = 1'b0; wait_n(2);
  endtask

  task automatic release_cs();
    cs_n = 1'b1; wait_n(3);
    chk("R6 oe off", {15'd0, sdo_oe}, 16'd0);
    chk("R6 sdo quiet", {15'd0, sdo}, 16'd0);
    exp_ch = ~exp_ch;
    chk("R2 channel flip", {15'd0, chan_sel}, {15'd0, exp_ch});
  endtask

  task automatic ext_frame(input logic [11:0] w);
    sclk = 1'b0; conv_word = w; wait_n(1);
    cs_n = 1'b0; wait_n(2);
    chk("R1 ext oe", {15'd0, sdo_oe}, 16'd1);
    for (int k = 1; k <= 20; k++) begin
      if (k == 3) conv_word = ~w;
      chk(k > 16 ? "R7 zero fill" : "R3 R4 ext bit", {15'd0, sdo}, {15'd0, fbit(exp_ch, w, k)});
      pulse();
    end
    release_cs();
  endtask

  task automatic int_frame(input logic [11:0] w, input bit busy_pulses);
    sclk = 1'b1; conv_word = w; wait_n(1);
    cs_n = 1'b0; wait_n(2);
    chk("R1 int oe", {15'd0, sdo_oe}, 16'd1);
    chk("R1 int low", {15'd0, sdo}, 16'd0);
    sclk = 1'b0; wait_n(1);
    conv_word = ~w;
    if (!busy_pulses) begin
      wait_n(CONV - 1);
      chk("R8 busy low", {15'd0, sdo}, 16'd0);
      wait_n(1);
      chk("R8 eoc high", {15'd0, sdo}, 16'd1);
    end else begin
      wait_n(10);
      for (int p = 0; p < 5; p++) pulse();
      chk("R8 edges ignored", {15'd0, sdo}, 16'd0);
      wait_n(CONV);
      chk("R8 eoc after busy", {15'd0, sdo}, 16'd1);
    end
    for (int k = 2; k <= 20; k++) begin
      pulse();
      chk(k > 16 ? "R7 R9 zero fill" : "R3 R9 int bit", {15'd0, sdo}, {15'd0, fbit(exp_ch, w, k)});
    end
    release_cs();
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk("R6 reset oe", {15'd0, sdo_oe}, 16'd0);
    chk("R6 reset sdo", {15'd0, sdo}, 16'd0);
    chk("R2 reset channel", {15'd0, chan_sel}, 16'd0);

    foreach (VEC[i]) begin
      if (VEC[i][12]) int_frame(VEC[i][11:0], 1'b0);
      else            ext_frame(VEC[i][11:0]);
    end

    int_frame(12'h6E3, 1'b1);

    // R10 abandon during busy
    sclk = 1'b1; conv_word = 12'h123; wait_n(1);
    cs_n = 1'b0; wait_n(2);
    sclk = 1'b0; wait_n(50);
    chk("R10 busy before abort", {15'd0, sdo}, 16'd0);
    release_cs();
    ext_frame(12'h9D2);
    int_frame(12'h47B, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule